// File: doc/BRIEF.md
# Polarity-Conditioned Interrupt Combiner

This block conditions five internal event lines before they reach a controller through a single interrupt output. Each line passes through a per-bit polarity XNOR, which produces a conditioned event. The conditioned event either feeds a status bit directly or sets a latch that holds until software clears it. The bits that software has enabled are ORed into one registered, active-high interrupt request.

Software reaches four 16-bit registers through a flat write/read port: polarity, sticky select, enable and status. Writes take effect at a clock edge, and reads are combinational. To clear a latched status bit, software writes 0 to that bit. A typical service loop handles the sources from bit 4 down to bit 0, clears each one it serviced, and then checks the interrupt line again.

Top module: `evt_irq_combiner`

## Requirements
- R1: Reset is asynchronous and active low. After reset, the polarity register (address 0x4E) reads 0x001F, the sticky register (0x50) reads 0x0000, the enable register (0x52) reads 0x0000 and `irq_o` is 0.
- R2: For a bit with sticky = 0, the status register (0x54) bit equals the event input XNOR the polarity bit in the same cycle. Polarity 1 means the event is active high and polarity 0 means it is active low.
- R3: For a bit with sticky = 1, the status bit is set at the clock edge after the conditioned event is true. It stays set after the event goes inactive.
- R4: Writing 0 to a bit of the status register clears that latched sticky bit at the write edge. Writing 1 to a status bit has no effect.
- R5: If a sticky bit's conditioned event is still true at the clear write, the bit reads 0 for one cycle and is set again at the next edge.
- R6: `irq_o` is a register that holds the OR of (status AND enable) as sampled at the previous clock edge. A bit whose enable is 0 never raises it.
- R7: `irq_o` stays asserted while any enabled status bit remains set, even after other bits have been cleared.
- R8: Source bits occupy data bits [4:0], with bit 4 the highest-priority source. In all four registers, bits [15:5] read as 0 and ignore writes.
- R9: A read of any address other than 0x4E, 0x50, 0x52 and 0x54 returns 0. A write to any such address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 5 | Raw event lines, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| irq_o | output | 1 | Registered global interrupt request |

## Verification
On every cycle, the embedded assertions check four things: the interrupt register against the enabled status of the previous cycle, that latched sticky bits hold, that a zero-write clears its bit, and that unused and unmapped read data stays zero. Only the bench scenarios can show the rest. These are the reset values, the active-low polarity path, the one-cycle gap when a clear hits an active event, that writing ones leaves the status unchanged, and that the interrupt stays up across a partial clear of several pending sources.

// File: rtl/evt_irq_combiner.sv
module evt_irq_combiner #(
  parameter int unsigned NSRC    = 5,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 16,
  parameter logic [7:0]  A_POL   = 8'h4E,
  parameter logic [7:0]  A_STK   = 8'h50,
  parameter logic [7:0]  A_EN    = 8'h52,
  parameter logic [7:0]  A_STAT  = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);

  localparam int unsigned PAD_W = DATA_W - NSRC;

  logic [NSRC-1:0] pol_q, stk_q, en_q, lat_q;
  logic [NSRC-1:0] cond, status, clr;
  logic            hit_pol, hit_stk, hit_en, hit_stat;
  logic            unused_hi;

  assign unused_hi = ^reg_wdata[DATA_W-1:NSRC];

  assign hit_pol  = (reg_addr == ADDR_W'(A_POL));
  assign hit_stk  = (reg_addr == ADDR_W'(A_STK));
  assign hit_en   = (reg_addr == ADDR_W'(A_EN));
  assign hit_stat = (reg_addr == ADDR_W'(A_STAT));

  assign cond   = ~(evt_i ^ pol_q);
  assign clr    = (reg_we && hit_stat) ? ~reg_wdata[NSRC-1:0] : '0;
  assign status = (stk_q & lat_q) | (~stk_q & cond);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '1;
      stk_q <= '0;
      en_q  <= '0;
    end else if (reg_we) begin
      if (hit_pol) pol_q <= reg_wdata[NSRC-1:0];
      if (hit_stk) stk_q <= reg_wdata[NSRC-1:0];
      if (hit_en)  en_q  <= reg_wdata[NSRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q | cond) & ~clr & stk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |(status & en_q);
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_pol)  reg_rdata = {{PAD_W{1'b0}}, pol_q};
    if (hit_stk)  reg_rdata = {{PAD_W{1'b0}}, stk_q};
    if (hit_en)   reg_rdata = {{PAD_W{1'b0}}, en_q};
    if (hit_stat) reg_rdata = {{PAD_W{1'b0}}, status};
  end

  // R6: interrupt register reflects last cycle's enabled status
  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status & en_q))));

  // R3: a latched sticky bit that is not cleared stays set
  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & stk_q & $past(status & stk_q & ~clr))
              == (stk_q & $past(status & stk_q & ~clr))));

  // R4: zero-write clears the sticky bit at the write edge
  p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & stk_q & $past(clr & stk_q)) == '0));

  // R8: unused upper data bits always read zero
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:NSRC] == '0);

  // R9: unmapped addresses read zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_pol || hit_stk || hit_en || hit_stat) |-> (reg_rdata == '0));

endmodule

// File: tb/test_evt_irq_combiner.sv
module test_evt_irq_combiner;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt_i = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  evt_irq_combiner i_evt_irq_combiner (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        we;
    logic [7:0]  waddr;
    logic [15:0] wdata;
    logic [4:0]  evt;
    logic [7:0]  raddr;
    logic [15:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h4E, 16'h001F, 1'b0, 4'd1}, // R1
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h50, 16'h0000, 1'b0, 4'd1}, // R1
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h52, 16'h0000, 1'b0, 4'd1}, // R1
    '{1'b0, 8'h00, 16'h0000, 5'b00101, 8'h54, 16'h0005, 1'b0, 4'd2}, // R2 active high
    '{1'b1, 8'h4E, 16'h001E, 5'b00000, 8'h54, 16'h0001, 1'b0, 4'd2}, // R2 active low bit0
    '{1'b1, 8'h4E, 16'hFFFF, 5'b00000, 8'h4E, 16'h001F, 1'b0, 4'd8}, // R8 upper ignored
    '{1'b1, 8'h52, 16'h001F, 5'b00000, 8'h52, 16'h001F, 1'b0, 4'd6},
    '{1'b0, 8'h00, 16'h0000, 5'b00010, 8'h54, 16'h0002, 1'b1, 4'd6}, // R6
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0000, 1'b0, 4'd2}, // R2 live follow
    '{1'b1, 8'h50, 16'h0018, 5'b00000, 8'h50, 16'h0018, 1'b0, 4'd3},
    '{1'b0, 8'h00, 16'h0000, 5'b10000, 8'h54, 16'h0010, 1'b0, 4'd3}, // R3 capture
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0010, 1'b1, 4'd3}, // R3 hold
    '{1'b1, 8'h54, 16'h001F, 5'b00000, 8'h54, 16'h0010, 1'b1, 4'd4}, // R4 ones no effect
    '{1'b1, 8'h54, 16'h0000, 5'b00000, 8'h54, 16'h0000, 1'b1, 4'd4}, // R4 clear
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0000, 1'b0, 4'd6},
    '{1'b0, 8'h00, 16'h0000, 5'b01000, 8'h54, 16'h0008, 1'b0, 4'd3},
    '{1'b1, 8'h54, 16'h0017, 5'b01000, 8'h54, 16'h0000, 1'b1, 4'd5}, // R5 clear while active
    '{1'b0, 8'h00, 16'h0000, 5'b01000, 8'h54, 16'h0008, 1'b0, 4'd5}, // R5 re-set
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0008, 1'b1, 4'd3},
    '{1'b1, 8'h52, 16'h0000, 5'b00000, 8'h54, 16'h0008, 1'b1, 4'd6},
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h52, 16'h0000, 1'b0, 4'd6}, // R6 enable gate
    '{1'b1, 8'h60, 16'hFFFF, 5'b00000, 8'h60, 16'h0000, 1'b0, 4'd9}, // R9
    '{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h50, 16'h0018, 1'b0, 4'd9}  // R9 no side effect
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input int req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    @(negedge clk);
    reg_we = v.we; reg_addr = v.waddr; reg_wdata = v.wdata; evt_i = v.evt;
    @(posedge clk);
    #1;
    reg_we = 1'b0; reg_addr = v.raddr;
    #1;
    check(reg_rdata, v.exp_rd, int'(v.req), "rdata");
    check({15'd0, irq_o}, {15'd0, v.exp_irq}, int'(v.req), "irq");
  endtask

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    foreach (VT[i]) step(VT[i]);

    // R1: reset in mid-run restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    #1; reg_addr = 8'h4E; #0.5; check(reg_rdata, 16'h001F, 1, "reset pol");
    reg_addr = 8'h50; #0.5; check(reg_rdata, 16'h0000, 1, "reset stk");
    reg_addr = 8'h54; #0.5; check(reg_rdata, 16'h0000, 1, "reset stat");
    check({15'd0, irq_o}, 16'h0000, 1, "reset irq");
    @(negedge clk);
    rst_n = 1'b1;

    // R7: partial clear keeps request up
    step('{1'b1, 8'h52, 16'h001F, 5'b00000, 8'h52, 16'h001F, 1'b0, 4'd7});
    step('{1'b1, 8'h50, 16'h001F, 5'b00000, 8'h50, 16'h001F, 1'b0, 4'd7});
    step('{1'b0, 8'h00, 16'h0000, 5'b00011, 8'h54, 16'h0003, 1'b0, 4'd7});
    step('{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0003, 1'b1, 4'd7});
    step('{1'b1, 8'h54, 16'h001D, 5'b00000, 8'h54, 16'h0001, 1'b1, 4'd7});
    step('{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0001, 1'b1, 4'd7}); // R7 held
    step('{1'b1, 8'h54, 16'h001E, 5'b00000, 8'h54, 16'h0000, 1'b1, 4'd7});
    step('{1'b0, 8'h00, 16'h0000, 5'b00000, 8'h54, 16'h0000, 1'b0, 4'd7});

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule